// File: doc/BRIEF.md
# Masked Data Address Overlay Redirector

This unit sits in the data path of a processor and checks each data access address against a set of overlay block descriptors. Each descriptor covers a block whose size is a power of two and whose start is aligned to that size. When an enabled descriptor matches, the access is sent to overlay memory: the unit swaps the block-base bits of the address for the descriptor's overlay base and keeps the offset inside the block. Calibration code uses this to patch constant data without changing it in place.

Software loads the target base, the mask and the overlay base of each descriptor through a simple write port. Software does not write the enable bits directly. They go into a shadow register, and one commit strobe copies all of them to the active set at once, so several overlay ranges turn on or off in the same clock cycle. The result of each lookup comes out one cycle after the access is presented: the final address, a hit flag and the number of the block that matched.

Top module: `ovl_redirect`

## Requirements
- R1: An access is a candidate for redirection only when its segment nibble acc_addr[31:28] equals 4'h8 or 4'hA. An access in any other segment never hits.
- R2: A block matches when it is active, the access is a candidate and the 28-bit segment offset acc_addr[27:0] equals the block's target base in every bit of [27:22] and in every bit of [21:0] where the block's mask is one. Mask-zero bits are ignored.
- R3: When no block matches, out_addr equals the incoming address unchanged and out_hit is 0.
- R4: On a hit, out_addr[31:28] is copied from acc_addr[31:28].
- R5: On a hit, out_addr[27:22] is taken from bits [27:22] of the matching block's overlay base.
- R6: On a hit, each bit of out_addr[21:0] comes from the overlay base where the mask bit is one and from the incoming address where the mask bit is zero.
- R7: When several blocks match, the block with the lowest number wins, and out_idx gives its number.
- R8: en_shadow_we loads en_shadow_data into a shadow register, which has no effect on matching. en_commit copies the whole shadow to the 16 active enable bits in one cycle.
- R9: out_valid, out_addr, out_hit and out_idx are registered one cycle after acc_valid/acc_addr. When acc_valid is low, out_valid and out_hit are 0 in the following cycle.
- R10: cfg_we writes cfg_wdata into block cfg_blk, into the field chosen by cfg_sel. The encodings are 0 for the target base (bits [27:0]), 1 for the mask (bits [21:0]) and 2 for the overlay base (bits [27:0]). An access presented in the same cycle as the write still sees the old value.
- R11: After reset, all active and shadow enables are 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_blk | input | 4 | Descriptor number to write |
| cfg_sel | input | 2 | Field select: 0 target base, 1 mask, 2 overlay base |
| cfg_wdata | input | 32 | Write data |
| en_shadow_we | input | 1 | Load the shadow enable register |
| en_shadow_data | input | 16 | New shadow enable bits, one per block |
| en_commit | input | 1 | Copy the shadow enables to the active enables |
| acc_valid | input | 1 | Access address valid |
| acc_addr | input | 32 | Incoming data access address |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | 32 | Final (redirected or original) address |
| out_hit | output | 1 | A block matched |
| out_idx | output | 4 | Number of the winning block |

## Verification
The hardest case to reach from the ports is a shadow enable pattern that has been written but not yet committed. Accesses made at that point must behave as if the write never happened. The bench writes the shadow to enable a block whose descriptor matches a probe address, then sends that probe before the commit. It repeats the probe after the commit, and again in the same cycle as a descriptor rewrite, which also exercises R10. Overlapping blocks with different mask sizes are loaded so that a single address matches two blocks at once. This exposes any error in the priority order.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

  typedef enum logic [1:0] {
    SEL_TBASE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_OBASE = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  function automatic logic seg_is_candidate(input logic [3:0] seg);
    return (seg == 4'h8) || (seg == 4'hA);
  endfunction

endpackage

// File: rtl/ovl_desc_regs.sv
module ovl_desc_regs
  import ovl_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int OFS_W = 28,
  parameter int LOW_W = 22,
  parameter int DAT_W = 32,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            cfg_we,
  input  logic [IDX_W-1:0]                cfg_blk,
  input  logic [1:0]                      cfg_sel,
  input  logic [DAT_W-1:0]                cfg_wdata,
  input  logic                            en_shadow_we,
  input  logic [NBLK-1:0]                 en_shadow_data,
  input  logic                            en_commit,
  output logic [NBLK-1:0]                 en_active,
  output logic [NBLK-1:0][OFS_W-1:0]      tbase,
  output logic [NBLK-1:0][LOW_W-1:0]      mask,
  output logic [NBLK-1:0][OFS_W-1:0]      obase
);

  logic [NBLK-1:0] en_shadow_q;
  logic [NBLK-1:0] en_active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_shadow_q <= '0;
      en_active_q <= '0;
    end else begin
      if (en_commit)    en_active_q <= en_shadow_q;
      if (en_shadow_we) en_shadow_q <= en_shadow_data;
    end
  end

  assign en_active = en_active_q;

  for (genvar b = 0; b < NBLK; b++) begin : g_desc
    logic [OFS_W-1:0] tbase_q;
    logic [LOW_W-1:0] mask_q;
    logic [OFS_W-1:0] obase_q;
    logic             sel_here;

    assign sel_here = cfg_we && (cfg_blk == IDX_W'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        tbase_q <= '0;
        mask_q  <= '0;
        obase_q <= '0;
      end else if (sel_here) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_TBASE: tbase_q <= cfg_wdata[OFS_W-1:0];
          SEL_MASK:  mask_q  <= cfg_wdata[LOW_W-1:0];
          SEL_OBASE: obase_q <= cfg_wdata[OFS_W-1:0];
          default:   ;
        endcase
      end
    end

    assign tbase[b] = tbase_q;
    assign mask[b]  = mask_q;
    assign obase[b] = obase_q;
  end

  AST_ENABLES_HELD: assert property (@(posedge clk) disable iff (rst)
    !en_commit |=> $stable(en_active_q)); // R8

  AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (rst)
    (en_commit && !en_shadow_we) |=> (en_active_q == en_shadow_q)); // R8

endmodule

// File: rtl/ovl_match.sv
module ovl_match
  import ovl_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int SEG_W = 4,
  parameter int OFS_W = 28,
  parameter int LOW_W = 22,
  localparam int ADDR_W = SEG_W + OFS_W,
  localparam int HI_W   = OFS_W - LOW_W
) (
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NBLK-1:0]                 en_active,
  input  logic [NBLK-1:0][OFS_W-1:0]      tbase,
  input  logic [NBLK-1:0][LOW_W-1:0]      mask,
  output logic [NBLK-1:0]                 match
);

  logic             cand;
  logic [OFS_W-1:0] ofs;

  assign cand = seg_is_candidate(addr[ADDR_W-1 -: SEG_W]);
  assign ofs  = addr[OFS_W-1:0];

  for (genvar b = 0; b < NBLK; b++) begin : g_cmp
    logic [OFS_W-1:0] cmp_mask;
    logic [OFS_W-1:0] diff;
    assign cmp_mask = {{HI_W{1'b1}}, mask[b]};
    assign diff     = (ofs ^ tbase[b]) & cmp_mask;
    assign match[b] = en_active[b] && cand && (diff == '0);
  end

  always_comb begin
    AST_NO_MATCH_OUTSIDE: assert (cand || (match == '0)); // R1
  end

endmodule

// File: rtl/ovl_prio.sv
module ovl_prio #(
  parameter int NBLK = 16,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic [NBLK-1:0]  match,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [NBLK-1:0]  grant
);

  always_comb begin
    any   = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < NBLK; i++) begin
      if (match[i] && !any) begin
        any      = 1'b1;
        idx      = IDX_W'(i);
        grant[i] = 1'b1;
      end
    end
  end

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(grant)); // R7
    AST_WINNER_MATCHES: assert ((grant & match) == grant); // R7
    AST_ANY_IFF_MATCH: assert (any == (match != '0)); // R7
  end

endmodule

// File: rtl/ovl_redirect.sv
module ovl_redirect
  import ovl_pkg::*;
#(
  parameter int NBLK  = 16,
  parameter int SEG_W = 4,
  parameter int OFS_W = 28,
  parameter int LOW_W = 22,
  localparam int ADDR_W = SEG_W + OFS_W,
  localparam int IDX_W  = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_blk,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              en_shadow_we,
  input  logic [NBLK-1:0]   en_shadow_data,
  input  logic              en_commit,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_hit,
  output logic [IDX_W-1:0]  out_idx
);

  logic [NBLK-1:0]            en_active;
  logic [NBLK-1:0][OFS_W-1:0] tbase;
  logic [NBLK-1:0][LOW_W-1:0] mask;
  logic [NBLK-1:0][OFS_W-1:0] obase;
  logic [NBLK-1:0]            match;
  logic [NBLK-1:0]            grant;
  logic                       any;
  logic [IDX_W-1:0]           idx;

  ovl_desc_regs #(
    .NBLK(NBLK), .OFS_W(OFS_W), .LOW_W(LOW_W), .DAT_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_blk(cfg_blk), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .en_shadow_we(en_shadow_we), .en_shadow_data(en_shadow_data), .en_commit(en_commit),
    .en_active(en_active), .tbase(tbase), .mask(mask), .obase(obase)
  );

  ovl_match #(
    .NBLK(NBLK), .SEG_W(SEG_W), .OFS_W(OFS_W), .LOW_W(LOW_W)
  ) u_match (
    .addr(acc_addr), .en_active(en_active), .tbase(tbase), .mask(mask), .match(match)
  );

  ovl_prio #(.NBLK(NBLK)) u_prio (
    .match(match), .any(any), .idx(idx), .grant(grant)
  );

  logic [OFS_W-1:0]  sel_obase;
  logic [LOW_W-1:0]  sel_mask;
  logic [OFS_W-1:0]  new_ofs;
  logic [ADDR_W-1:0] next_addr;

  assign sel_obase = obase[idx];
  assign sel_mask  = mask[idx];
  assign new_ofs   = {sel_obase[OFS_W-1:LOW_W],
                      (sel_obase[LOW_W-1:0] & sel_mask) |
                      (acc_addr[LOW_W-1:0] & ~sel_mask)};
  assign next_addr = any ? {acc_addr[ADDR_W-1 -: SEG_W], new_ofs} : acc_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_hit   <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= acc_valid;
      out_addr  <= next_addr;
      out_hit   <= acc_valid && any;
      out_idx   <= idx;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid); // R9
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!out_valid && !out_hit)); // R9
  AST_MISS_PASS: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !any) |=> (out_addr == $past(acc_addr) && !out_hit)); // R3
  AST_SEG_KEPT: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (out_addr[ADDR_W-1 -: SEG_W] == $past(acc_addr[ADDR_W-1 -: SEG_W]))); // R4
  AST_HIT_SEGMENT: assert property (@(posedge clk) disable iff (rst)
    out_hit |-> seg_is_candidate(out_addr[ADDR_W-1 -: SEG_W])); // R1

endmodule

// File: tb/ovl_redirect_test.sv
`timescale 1ns/1ps
module ovl_redirect_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_blk = '0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        en_shadow_we = 1'b0;
  logic [15:0] en_shadow_data = '0;
  logic        en_commit = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        out_hit;
  logic [3:0]  out_idx;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  ovl_redirect uut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_blk(cfg_blk), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .en_shadow_we(en_shadow_we), .en_shadow_data(en_shadow_data), .en_commit(en_commit),
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .out_valid(out_valid), .out_addr(out_addr), .out_hit(out_hit), .out_idx(out_idx)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] exp_addr;
    logic        exp_hit;
    logic [3:0]  exp_idx;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h8010_0ABC, 32'h83C0_5ABC, 1'b1, 4'd2},  // R7 overlap 2/5, R6
    '{32'hA010_0ABC, 32'hA3C0_5ABC, 1'b1, 4'd2},  // R1 segment A, R4
    '{32'h9010_0ABC, 32'h9010_0ABC, 1'b0, 4'd0},  // R1 segment 9 ignored
    '{32'h8010_1ABC, 32'h8080_1ABC, 1'b1, 4'd5},  // R2 larger block, R6
    '{32'h8410_0ABC, 32'h8410_0ABC, 1'b0, 4'd0},  // R2 upper offset bits compared
    '{32'h8020_0010, 32'h8020_0010, 1'b0, 4'd0},  // R2 disabled block, R3
    '{32'h8030_0000, 32'h8140_0000, 1'b1, 4'd0},  // R7 block 0
    '{32'h8030_0004, 32'h8140_0004, 1'b1, 4'd0},  // R6 offset kept
    '{32'h8038_0000, 32'h80C0_0000, 1'b1, 4'd15}, // R5 fixed upper bits
    '{32'h0010_0ABC, 32'h0010_0ABC, 1'b0, 4'd0}   // R1 segment 0
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] blk, input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_blk = blk; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic shadow(input logic [15:0] d, input logic commit);
    @(negedge clk);
    en_shadow_we = 1'b1; en_shadow_data = d;
    @(negedge clk);
    en_shadow_we = 1'b0;
    if (commit) begin
      en_commit = 1'b1;
      @(negedge clk);
      en_commit = 1'b0;
    end
  endtask

  task automatic probe(input logic [31:0] a, input logic [31:0] ea, input logic eh,
                       input logic [3:0] ei, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " addr"}, out_addr, ea);
    chk({req, " hit"}, {31'd0, out_hit}, {31'd0, eh});
    if (eh) chk({req, " idx"}, {28'd0, out_idx}, {28'd0, ei});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 valid", {31'd0, out_valid}, 32'd0);
    chk("R11 addr", out_addr, 32'd0);
    chk("R11 hit", {31'd0, out_hit}, 32'd0);
    // R11 enables off: a would-be match misses before any commit
    cfg(4'd2, 2'd0, 32'h0010_0000);
    cfg(4'd2, 2'd1, 32'h003F_F000);
    probe(32'h8010_0ABC, 32'h8010_0ABC, 1'b0, 4'd0, "R11 enables off");

    // R10 descriptor loading
    cfg(4'd2, 2'd2, 32'h03C0_5000);
    cfg(4'd5, 2'd0, 32'h0010_0000);
    cfg(4'd5, 2'd1, 32'h003F_0000);
    cfg(4'd5, 2'd2, 32'h0080_0000);
    cfg(4'd7, 2'd0, 32'h0020_0000);
    cfg(4'd7, 2'd1, 32'h003F_FF00);
    cfg(4'd7, 2'd2, 32'h0100_0000);
    cfg(4'd0, 2'd0, 32'h0030_0000);
    cfg(4'd0, 2'd1, 32'h003F_FF00);
    cfg(4'd0, 2'd2, 32'h0140_0000);
    cfg(4'd15, 2'd0, 32'h0038_0000);
    cfg(4'd15, 2'd1, 32'h003F_FFFF);
    cfg(4'd15, 2'd2, 32'h00C0_0000);
    shadow(16'h8025, 1'b1);

    for (int i = 0; i < NV; i++) begin
      probe(VECS[i].addr, VECS[i].exp_addr, VECS[i].exp_hit, VECS[i].exp_idx,
            $sformatf("R2/R3/R6 vector %0d", i));
    end

    // R9 idle cycle
    @(negedge clk);
    chk("R9 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R9 idle hit", {31'd0, out_hit}, 32'd0);

    // R8 shadow written but not committed: no effect
    shadow(16'h80A5, 1'b0);
    probe(32'h8020_0010, 32'h8020_0010, 1'b0, 4'd0, "R8 before commit");
    @(negedge clk);
    en_commit = 1'b1;
    @(negedge clk);
    en_commit = 1'b0;
    probe(32'h8020_0010, 32'h8100_0010, 1'b1, 4'd7, "R8 after commit");

    // R10 write in same cycle as access sees old value, next access new
    @(negedge clk);
    cfg_we = 1'b1; cfg_blk = 4'd7; cfg_sel = 2'd2; cfg_wdata = 32'h0040_0000;
    acc_valid = 1'b1; acc_addr = 32'h8020_0010;
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
    chk("R10 same-cycle old value", out_addr, 32'h8100_0010);
    probe(32'h8020_0010, 32'h8040_0010, 1'b1, 4'd7, "R10 new value");

    // R9 back-to-back accesses, one cycle apart
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 32'h8010_1ABC;
    @(negedge clk);
    acc_addr = 32'h9000_0000;
    chk("R9 pipe first", out_addr, 32'h8080_1ABC);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R9 pipe second", out_addr, 32'h9000_0000);

    // R8 all enables off together
    shadow(16'h0000, 1'b1);
    probe(32'h8010_0ABC, 32'h8010_0ABC, 1'b0, 4'd0, "R8 all off");
    probe(32'h8038_0000, 32'h8038_0000, 1'b0, 4'd0, "R8 all off b15");

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule